// File: doc/BRIEF.md
# Key Output Override Path

This block carries three key inputs and one power-button input through to their output pins. Each path can be inverted on the way in and again on the way out. It also drives two board control pins, an active-low reset line for an embedded controller and an active-low flash write-protect line. When no override applies, both rest high.

A debounced press of the power button (a falling level) can auto-block selected key outputs: while the filtered button stays low, each selected key output is forced to a programmed value. On top of that, software can force any of the six outputs to 0 or 1. The forcing takes effect only when the value asked for is permitted by a per-pin pair of allow bits: one bit permits driving 0 and the other permits driving 1. All configuration arrives as static input words from a register file outside this block.

Top module: `key_ovr_path`

## Requirements
- R1: With no auto-block and no override, key_out[i] = key_in[i] ^ in_inv[i] ^ out_inv[i] for i = 0..2, and btn_out = btn_in ^ in_inv[3] ^ out_inv[3].
- R2: After reset the filtered button level is high and auto-block is inactive. ec_rst_l and wp_l are 1 when no override applies.
- R3: Auto-block is active only while ab_en is 1 and the filtered button level is low. While it is active, each key with ab_sel[i] = 1 outputs ab_val[i] (before output inversion), unselected keys pass through, and btn_out is not affected.
- R4: The filtered button level takes a new value only after the button input has been sampled at that value on ab_thr + 2 consecutive rising edges. It changes on the last of those edges.
- R5: A change of the button input before the count completes restarts the count from zero.
- R6: Auto-block releases when the filtered button level returns high, using the same timing as R4.
- R7: Pin bit order is key0, key1, key2, button, ec_rst_l, wp_l (bits 0 to 5). When ovr_en[p] = 1 and the requested ovr_val[p] is permitted (allow_zero[p] for 0, allow_one[p] for 1), the pin takes ovr_val[p]. This takes priority over pass-through and auto-block.
- R8: An override whose value is not permitted has no effect, and the pin keeps its normal value.
- R9: Output inversion (out_inv, bits 0..3) is applied last, after any override. ec_rst_l and wp_l are never inverted.
- R10: The debounce filter watches the button after input inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| key_in | input | 3 | raw key inputs |
| btn_in | input | 1 | raw power-button input |
| in_inv | input | 4 | input invert enables: keys 0..2, button at bit 3 |
| out_inv | input | 4 | output invert enables: keys 0..2, button at bit 3 |
| ab_en | input | 1 | auto-block enable |
| ab_thr | input | 16 | debounce threshold in cycles |
| ab_sel | input | 3 | keys subject to auto-block |
| ab_val | input | 3 | forced key values during auto-block |
| ovr_en | input | 6 | per-pin override enable |
| ovr_val | input | 6 | per-pin override value |
| allow_zero | input | 6 | per-pin permission to force 0 |
| allow_one | input | 6 | per-pin permission to force 1 |
| key_out | output | 3 | key output pins |
| btn_out | output | 1 | button output pin |
| ec_rst_l | output | 1 | controller reset pin, active low |
| wp_l | output | 1 | flash write-protect pin, active low |

## Verification
The only state is the debounce sampler, its counter and the filtered level, and every error in them becomes visible through the auto-blocked keys. If the counter is off by one, the forced key values appear one edge early or late compared with the ab_thr + 2 edge point. If the restart is missing, a short glitch is enough to trigger the block. If the filtered level is stuck, the keys are never released. The bench therefore samples the key outputs on both sides of the exact switching edge, for press, release and interrupted press.

// File: rtl/key_ovr_path.sv
module key_ovr_path #(
  parameter int TW = 16,
  parameter int NK = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NK-1:0] key_in,
  input  logic          btn_in,
  input  logic [NK:0]   in_inv,
  input  logic [NK:0]   out_inv,
  input  logic          ab_en,
  input  logic [TW-1:0] ab_thr,
  input  logic [NK-1:0] ab_sel,
  input  logic [NK-1:0] ab_val,
  input  logic [NK+2:0] ovr_en,
  input  logic [NK+2:0] ovr_val,
  input  logic [NK+2:0] allow_zero,
  input  logic [NK+2:0] allow_one,
  output logic [NK-1:0] key_out,
  output logic          btn_out,
  output logic          ec_rst_l,
  output logic          wp_l
);
  localparam int NP = NK + 3;

  logic [NK:0]   pass;
  logic          samp_q, deb_q, blk;
  logic [TW-1:0] cnt_q;
  logic [NP-1:0] base, permit, drv, outs, oinv;

  assign pass = {btn_in, key_in} ^ in_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b1;
      deb_q  <= 1'b1;
      cnt_q  <= '0;
    end else if (pass[NK] != samp_q) begin
      samp_q <= pass[NK];
      cnt_q  <= '0;
    end else if (samp_q != deb_q) begin
      if (cnt_q >= ab_thr) begin
        deb_q <= samp_q;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign blk = ab_en & ~deb_q;

  always_comb begin
    base = {2'b11, pass};
    for (int i = 0; i < NK; i++)
      if (blk && ab_sel[i]) base[i] = ab_val[i];
  end

  assign permit = ovr_en & ((ovr_val & allow_one) | (~ovr_val & allow_zero));
  assign drv    = (base & ~permit) | (ovr_val & permit);

  assign {btn_out, key_out} = drv[NK:0] ^ out_inv;
  assign ec_rst_l = drv[NK+1];
  assign wp_l     = drv[NK+2];

  assign outs = {wp_l, ec_rst_l, btn_out, key_out};
  assign oinv = {2'b00, out_inv};

  p_deb_from_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deb_q) |-> (deb_q == $past(samp_q)));

  p_deb_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(samp_q) |-> $stable(deb_q));

  for (genvar g = 0; g < NK; g++) begin : g_ab
    p_ab_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en && !deb_q && ab_sel[g] && !permit[g]) |-> (key_out[g] == (ab_val[g] ^ out_inv[g])));
  end

  for (genvar g = 0; g < NP; g++) begin : g_ovr
    p_ovr_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      permit[g] |-> ((outs[g] ^ oinv[g]) == ovr_val[g]));
  end
endmodule

// File: tb/sim_key_ovr_path.sv
module sim_key_ovr_path;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  key_in = 3'b010, ab_sel = '0, ab_val = '0, key_out;
  logic        btn_in = 1'b1, ab_en = 1'b0, btn_out, ec_rst_l, wp_l;
  logic [3:0]  in_inv = '0, out_inv = '0;
  logic [15:0] ab_thr = 16'd5;
  logic [5:0]  ovr_en = '0, ovr_val = '0, allow_zero = '0, allow_one = '0;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  key_ovr_path u0 (.clk(clk), .rst_n(rst_n), .key_in(key_in), .btn_in(btn_in),
    .in_inv(in_inv), .out_inv(out_inv), .ab_en(ab_en), .ab_thr(ab_thr),
    .ab_sel(ab_sel), .ab_val(ab_val), .ovr_en(ovr_en), .ovr_val(ovr_val),
    .allow_zero(allow_zero), .allow_one(allow_one), .key_out(key_out),
    .btn_out(btn_out), .ec_rst_l(ec_rst_l), .wp_l(wp_l));

  task automatic chk(string tag, logic [5:0] exp);
    logic [5:0] act;
    #1;
    act = {wp_l, ec_rst_l, btn_out, key_out};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    btn_in = 1'b1; in_inv = '0; out_inv = '0;
    step(12);
  endtask

  task automatic t_reset();
    step(2); rst_n = 1'b1;
    chk("R2 reset", 6'b111010);
  endtask

  task automatic t_pass();
    in_inv = 4'b0011; out_inv = 4'b0100; key_in = 3'b101;
    chk("R1 pattern a", 6'b111010);
    in_inv = 4'b0000; out_inv = 4'b1111; key_in = 3'b011;
    chk("R1 pattern b", 6'b110100);
    settle();
  endtask

  task automatic t_press();
    ab_en = 1'b1; ab_sel = 3'b011; ab_val = 3'b001; key_in = 3'b110;
    btn_in = 1'b0;
    step(6); chk("R4 not yet filtered", 6'b110110);
    step(1); chk("R3 R4 block active", 6'b110101);
    ab_en = 1'b0; chk("R3 enable off", 6'b110110);
    ab_en = 1'b1; chk("R3 enable on", 6'b110101);
  endtask

  task automatic t_release();
    btn_in = 1'b1;
    step(6); chk("R6 still blocked", 6'b111101);
    step(1); chk("R6 released", 6'b111110);
  endtask

  task automatic t_glitch();
    btn_in = 1'b0; step(4);
    btn_in = 1'b1; step(1);
    btn_in = 1'b0;
    step(6); chk("R5 restarted count", 6'b110110);
    step(1); chk("R5 block after restart", 6'b110101);
    settle();
  endtask

  task automatic t_in_inv_btn();
    in_inv = 4'b1000;
    step(6); chk("R10 not yet", 6'b110110);
    step(1); chk("R10 inverted press", 6'b110101);
    settle();
  endtask

  task automatic t_ovr();
    ovr_en = 6'b110001; ovr_val = 6'b000001; allow_one = 6'b000001; allow_zero = 6'b010000;
    chk("R7 idle override", 6'b101111);
    chk("R8 wp not permitted", 6'b101111);
    ovr_en = 6'b000011; ovr_val = 6'b000010; allow_zero = 6'b000011; allow_one = 6'b000000;
    btn_in = 1'b0; step(7);
    chk("R8 blocked key1 value one refused", 6'b110100);
    allow_one = 6'b000010;
    chk("R7 override over auto-block", 6'b110110);
    allow_one = 6'b000000;
    ovr_en = 6'b010011; allow_zero = 6'b010011; out_inv = 4'b1001;
    chk("R9 inversion after override", 6'b101101);
    ovr_en = '0; settle();
    chk("R2 pins rest high", 6'b111110);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pass();
    t_press();
    t_release();
    t_glitch();
    t_in_inv_btn();
    t_ovr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule